// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when an SDRAM controller must spend cycles on auto-refresh so that every row is refreshed within its retention window. A free-running interval timer adds one owed refresh each time a programmable number of clocks elapses. The owed refreshes are kept in a small saturating counter. While the counter is non-zero the block asks the controller for refresh time. When the counter is full, the block raises an urgent flag so that refresh takes priority over traffic.

When the controller holds the grant, the block issues refreshes back to back. They are spaced by the row cycle time, converted to whole clocks by rounding up. Each issued refresh produces a one-cycle done pulse. The burst ends when nothing is owed, when the grant is dropped, or when the burst reaches its maximum length. At a 10 ns clock and a 64 ms / 4096-row retention budget, the interval setting is about 1560 clocks. The 60 ns row cycle becomes 6 clocks.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_o, urgent_o and done_o are low, the owed count is zero and the interval timer starts from zero.
- R2: With interval_i = N (N ≥ 2), one refresh becomes owed at the N-th rising clock edge after reset release and then every N edges. A setting of 0 or 1 adds one owed refresh on every edge.
- R3: The owed count saturates at MAX_OWED (8). Intervals that expire while it is full are lost, so one refresh issued from a full count leaves 7 owed.
- R4: req_o is high exactly when at least one refresh is owed.
- R5: urgent_o is high exactly when the owed count equals MAX_OWED (8). urgent_o never rises without req_o.
- R6: A refresh is issued only on a rising edge where grant_i is high and at least one refresh is owed. done_o is high for the one cycle after that edge. Each issued refresh lowers the owed count by one. With grant_i low, no done_o pulse appears.
- R7: Two issued refreshes are at least TRC_CLKS = ceil(TRC_PS / CLK_PERIOD_PS) clocks apart (6 clocks at 60 ns and 10 ns). With grant_i held and refreshes owed, they are exactly TRC_CLKS apart. The spacing window keeps running while grant_i is low.
- R8: One uninterrupted grant_i hold issues at most MAX_BURST (8) refreshes. Dropping grant_i for at least one cycle re-enables issuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| interval_i | input | IVL_W | Clocks per refresh interval |
| grant_i | input | 1 | Controller grants refresh time |
| req_o | output | 1 | At least one refresh owed |
| urgent_o | output | 1 | Owed count at its cap; refresh must take priority |
| done_o | output | 1 | One-cycle pulse per issued refresh |

## Verification
On every cycle, the in-line assertions check several properties:
- the owed count never passes its cap and moves by exactly one per issued refresh;
- a done pulse is always preceded by a grant and a pending request;
- two pulses are never closer than the row cycle window;
- a grant hold never issues more than the burst limit;
- the interval timer restarts after each expiry.

Only the bench scenarios can show the exact counts. These include how many refreshes accumulate over a given idle time for several interval settings, and that saturation drops the excess. They also include how many done pulses a grant window of a given length yields, and that the spacing is exactly six clocks. Finally, the scenarios show that a one-cycle grant drop re-opens a capped burst.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

   // Clock count for a time minimum: divide and round up.
   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   // Bits needed to hold the values 0..max_val.
   function automatic int unsigned bits_for(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/refsch_interval_timer.sv
module refsch_interval_timer #(
   parameter int unsigned IVL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IVL_W-1:0] interval_i,
   output logic             tick_o
);
   logic [IVL_W-1:0] cnt_q;
   logic [IVL_W:0]   cnt_inc;

   // One bit wider, so that a setting of 0 or 1 fires every cycle.
   assign cnt_inc = {1'b0, cnt_q} + {{IVL_W{1'b0}}, 1'b1};
   assign tick_o  = (cnt_inc >= {1'b0, interval_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_inc[IVL_W-1:0];
   end

   // R2: every expiry restarts the count.
   assert_tick_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/refsch_debt_ctr.sv
module refsch_debt_ctr #(
   parameter int unsigned MAX_OWED = 8,
   parameter int unsigned OWED_W   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic fire_i,
   output logic pending_o,
   output logic urgent_o
);
   logic [OWED_W-1:0] owed_q, owed_d;

   localparam logic [OWED_W-1:0] CAP = OWED_W'(MAX_OWED);
   localparam logic [OWED_W-1:0] ONE = OWED_W'(1);

   always_comb begin
      owed_d = owed_q;
      if (tick_i && !fire_i) begin
         if (owed_q != CAP) owed_d = owed_q + ONE;
      end else if (fire_i && !tick_i) begin
         owed_d = owed_q - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owed_q <= '0;
      else        owed_q <= owed_d;
   end

   assign pending_o = (owed_q != '0);
   assign urgent_o  = (owed_q == CAP);

   // R3: the owed count never passes its cap.
   assert_owed_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      owed_q <= CAP);

   // R6: an issued refresh without a new expiry takes exactly one off.
   assert_owed_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i && !tick_i) |=> (owed_q == $past(owed_q) - ONE));

   // R6: the pacer never fires against an empty count.
   assert_fire_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |-> (owed_q != '0));

   // R1: the count is empty after reset.
   assert_reset_empty_R1: assert property (@(posedge clk)
      !rst_n |=> (owed_q == '0));

endmodule

// File: rtl/refsch_pacer.sv
module refsch_pacer #(
   parameter int unsigned TRC_CLKS  = 6,
   parameter int unsigned MAX_BURST = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic grant_i,
   input  logic pending_i,
   output logic fire_o,
   output logic done_o
);
   import refsch_pkg::*;

   localparam int unsigned BURST_W = bits_for(MAX_BURST);
   localparam int unsigned SINCE_W = bits_for(TRC_CLKS);
   localparam logic [BURST_W-1:0] BURST_CAP = BURST_W'(MAX_BURST);

   logic               window_open;
   logic [BURST_W-1:0] burst_q;

   generate
      if (TRC_CLKS > 1) begin : g_gap
         localparam int unsigned GAP_W = bits_for(TRC_CLKS - 1);
         logic [GAP_W-1:0] gap_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          gap_q <= '0;
            else if (fire_o)     gap_q <= GAP_W'(TRC_CLKS - 1);
            else if (gap_q != 0) gap_q <= gap_q - GAP_W'(1);
         end

         assign window_open = (gap_q == '0);

         // R7: no two pulses on neighbouring cycles.
         assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |=> !done_o);
      end else begin : g_nogap
         assign window_open = 1'b1;
      end
   endgenerate

   assign fire_o = grant_i && pending_i && window_open && (burst_q < BURST_CAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        burst_q <= '0;
      else if (!grant_i) burst_q <= '0;
      else if (fire_o)   burst_q <= burst_q + BURST_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_o <= 1'b0;
      else        done_o <= fire_o;
   end

   // Checker state: cycles since the last pulse, saturating at the window.
   logic [SINCE_W-1:0] since_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            since_q <= SINCE_W'(TRC_CLKS);
      else if (done_o)                       since_q <= SINCE_W'(1);
      else if (since_q != SINCE_W'(TRC_CLKS)) since_q <= since_q + SINCE_W'(1);
   end

   // R7: pulses are at least one row cycle apart.
   assert_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (since_q == SINCE_W'(TRC_CLKS)));

   // R8: a grant hold never issues more than the burst limit.
   assert_burst_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      burst_q <= BURST_CAP);

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
   parameter int unsigned CLK_PERIOD_PS = 10000,
   parameter int unsigned TRC_PS        = 60000,
   parameter int unsigned IVL_W         = 16,
   parameter int unsigned MAX_OWED      = 8,
   parameter int unsigned MAX_BURST     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IVL_W-1:0] interval_i,
   input  logic             grant_i,
   output logic             req_o,
   output logic             urgent_o,
   output logic             done_o
);
   import refsch_pkg::*;

   localparam int unsigned TRC_CLKS = ceil_div(TRC_PS, CLK_PERIOD_PS);
   localparam int unsigned OWED_W   = bits_for(MAX_OWED);

   generate
      if (CLK_PERIOD_PS == 0) begin : g_bad_period
         $error("CLK_PERIOD_PS must be non-zero");
      end
      if (MAX_OWED < 1) begin : g_bad_owed
         $error("MAX_OWED must be at least 1");
      end
      if (MAX_BURST < 1) begin : g_bad_burst
         $error("MAX_BURST must be at least 1");
      end
      if (IVL_W < 2) begin : g_bad_ivl
         $error("IVL_W must be at least 2");
      end
   endgenerate

   logic tick, fire, pending, urgent;

   refsch_interval_timer #(.IVL_W(IVL_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .interval_i (interval_i),
      .tick_o     (tick)
   );

   refsch_debt_ctr #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) u_debt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .fire_i    (fire),
      .pending_o (pending),
      .urgent_o  (urgent)
   );

   refsch_pacer #(.TRC_CLKS(TRC_CLKS), .MAX_BURST(MAX_BURST)) u_pacer (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant_i   (grant_i),
      .pending_i (pending),
      .fire_o    (fire),
      .done_o    (done_o)
   );

   assign req_o    = pending;
   assign urgent_o = urgent;

   // R6: a pulse follows a cycle with both grant and request.
   assert_done_needs_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(grant_i) && $past(req_o)));

   // R5: urgent implies a pending request.
   assert_urgent_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      urgent_o |-> req_o);

   // R1: outputs are quiet right after reset.
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!req_o && !done_o));

endmodule

// File: tb/test_sdram_refresh_sched.sv
`timescale 1ns/1ps
module test_sdram_refresh_sched;
   localparam int TRC = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] interval = 16'd0;
   logic        grant = 1'b0;
   logic        req, urgent, done;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sdram_refresh_sched i_sdram_refresh_sched (
      .clk(clk), .rst_n(rst_n), .interval_i(interval), .grant_i(grant),
      .req_o(req), .urgent_o(urgent), .done_o(done)
   );

   // Fields: interval, idle edges, req, urgent, grant edges, pulses, req after, urgent after
   localparam int NV = 6;
   localparam int VEC [NV][8] = '{
      '{20,  62, 1, 0, 15, 3, 0, 0},
      '{10,  91, 1, 1,  5, 1, 1, 0},
      '{50, 120, 1, 0, 25, 2, 0, 0},
      '{30,   5, 0, 0, 10, 0, 0, 0},
      '{ 5,  12, 1, 0,  1, 1, 1, 0},
      '{40, 330, 1, 1, 49, 8, 1, 0}
   };

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(input int ivl);
      @(negedge clk);
      rst_n = 1'b0; grant = 1'b0; interval = 16'(ivl);
      repeat (3) @(negedge clk);
      check("R1 req in reset", int'(req), 0);
      check("R1 done in reset", int'(done), 0);
      rst_n = 1'b1;
   endtask

   task automatic idle(input int edges, output int pulses);
      pulses = 0;
      grant = 1'b0;
      repeat (edges) begin
         @(negedge clk);
         if (done) pulses++;
      end
   endtask

   // R7: consecutive pulses within one grant hold must be TRC apart.
   task automatic granted(input int edges, output int pulses);
      int last;
      pulses = 0;
      last = -1;
      grant = 1'b1;
      for (int k = 1; k <= edges; k++) begin
         @(negedge clk);
         if (done) begin
            if (last >= 0) check("R7 spacing", k - last, TRC);
            last = k;
            pulses++;
         end
      end
      grant = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int p;
      // Vector walk: R2, R3, R4, R5, R6, R8
      for (int v = 0; v < NV; v++) begin
         do_reset(VEC[v][0]);
         idle(VEC[v][1], p);
         check("R6 no pulse without grant", p, 0);
         check("R2 R4 req after idle", int'(req), VEC[v][2]);
         check("R3 R5 urgent after idle", int'(urgent), VEC[v][3]);
         granted(VEC[v][4], p);
         check("R6 R8 pulses in grant", p, VEC[v][5]);
         check("R4 req after grant", int'(req), VEC[v][6]);
         check("R3 R5 urgent after grant", int'(urgent), VEC[v][7]);
      end

      // R2: interval 0 owes one refresh per edge
      do_reset(0);
      idle(3, p);
      check("R2 interval0 req", int'(req), 1);
      check("R2 interval0 urgent early", int'(urgent), 0);
      idle(5, p);
      check("R2 R5 interval0 urgent at 8", int'(urgent), 1);

      // R6/R7: grant dropped mid-burst, then resumed
      do_reset(100);
      idle(305, p);
      granted(1, p);
      check("R6 one-edge grant", p, 1);
      idle(10, p);
      check("R6 no pulse while grant low", p, 0);
      granted(20, p);
      check("R6 resumed grant", p, 2);
      check("R4 drained", int'(req), 0);

      // R8: capped burst re-opened by a one-cycle drop
      do_reset(40);
      idle(330, p);
      granted(49, p);
      check("R8 burst capped", p, 8);
      idle(1, p);
      granted(10, p);
      check("R8 reissue after drop", p, 1);
      check("R4 empty after reissue", int'(req), 0);

      // R1: reset in the middle of a full count
      do_reset(0);
      idle(10, p);
      check("R5 full before reset", int'(urgent), 1);
      do_reset(1000);
      @(negedge clk);
      check("R1 req after reset", int'(req), 0);
      check("R1 urgent after reset", int'(urgent), 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule